// File: doc/BRIEF.md
# OTP bank read controller

This block fetches one bank of a small one-time-programmable fuse array into a four-word readout window. It sits behind a simple register bus. Software writes the starting bit position of a bank into an address register. It then writes the control register with a read-pulse period and the start bit. The controller sequences four word reads from the array, each taking a fixed number of cycles set by the period. It latches the words into the window and raises a sticky done flag, which software clears by writing zero to it.

The fuse array itself is a behavioural model with a fixed per-word access latency, and its contents are computed rather than stored. A bank address that is misaligned or beyond the last bank finishes at once, with an all-zero window. Programming fuses, integrity checking, key loading and trimming are not part of this block.

Top module: `otp_bank_reader`

## Requirements
- R1: After reset, the control (0x48), status (0x4C) and address (0x50) registers and all four window words (0x20, 0x24, 0x28, 0x2C) read as zero.
- R2: A read of bank b (address b*128, b below 8) fills window word i (offset 0x20+4*i) with fuse word g = 4*b+i, whose value is 32'h9E3779B9 * (g+1) taken modulo 2^32.
- R3: With period P in control bits 15:8, done (status bit 4) is first visible 4*(P+1)+1 clock edges after the edge that accepts the start write. The start bit (control bit 2) reads 1 while the read is in flight and 0 once it completes.
- R4: Done is sticky. A status write with bit 4 at 0 clears it, and a status write with bit 4 at 1 leaves it set.
- R5: A control write while a read is in flight is ignored: the period, the timing and the fetched bank are unchanged. The bank is captured at start, so an address write during the read does not affect it.
- R6: A start with an address that is not a multiple of 128, or that is 1024 or above, sets done on the accepting edge and clears all window words to zero.
- R7: Control bits 0, 1, 3, 4 and 5 are not stored and read back as zero. Bits 15:8 read back the period last written while idle.
- R8: The address register reads back the last value written, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The hardest situation to reach from the ports is a control write that lands while a bank fetch is in flight. That write carries a different period and a fresh start bit, and the address register is rewritten too, so it must leave the timing and the fetched data untouched. The bench starts a slow read (period 10), issues the conflicting writes on the next bus cycles, and reads the control register mid-flight. It then times done against the original period and checks that the window holds the bank captured at start. Zero-period reads and misaligned or out-of-range addresses after a valid read cover the latency and window-clear extremes.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OFF_WIN  = 8'h20;
  localparam logic [7:0] OFF_CTRL = 8'h48;
  localparam logic [7:0] OFF_STAT = 8'h4C;
  localparam logic [7:0] OFF_ADDR = 8'h50;
  localparam int START_BIT = 2;
  localparam int DONE_BIT  = 4;
  localparam int PER_LSB   = 8;
  localparam logic [31:0] FUSE_SEED = 32'h9E3779B9;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/otp_fuse_model.sv
module otp_fuse_model #(
  parameter int WORD_W = 32,
  parameter int PER_W  = 8,
  parameter int GIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req,
  input  logic [GIDX_W-1:0] req_word,
  input  logic [PER_W-1:0]  req_period,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data
);
  logic              busy_q, busy_d;
  logic [PER_W-1:0]  cnt_q, cnt_d, per_q, per_d;
  logic [GIDX_W-1:0] word_q, word_d;
  logic [31:0]       raw;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    per_d  = per_q;
    word_d = word_q;
    if (req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      per_d  = req_period;
      word_d = req_word;
    end else if (busy_q) begin
      if (cnt_q == per_q) busy_d = 1'b0;
      else                cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      word_q <= word_d;
    end
  end

  assign raw        = otp_pkg::FUSE_SEED * (32'(word_q) + 32'd1);
  assign resp_valid = busy_q && (cnt_q == per_q);
  assign resp_data  = WORD_W'(raw);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    req |-> (!busy_q || resp_valid));
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq #(
  parameter int NUM_BANKS = 8,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int PER_W     = 8,
  localparam int BANK_BITS  = WORDS * WORD_W,
  localparam int OFF_W      = $clog2(BANK_BITS),
  localparam int BANK_IDX_W = $clog2(NUM_BANKS),
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int GIDX_W     = BANK_IDX_W + WIDX_W
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          start,
  input  logic [WORD_W-1:0]             bank_addr,
  input  logic [PER_W-1:0]              period,
  output logic                          busy,
  output logic                          done_set,
  output logic [WORDS-1:0][WORD_W-1:0]  win
);
  import otp_pkg::*;

  seq_state_t                  state_q, state_d;
  logic [WIDX_W-1:0]           idx_q, idx_d;
  logic [BANK_IDX_W-1:0]       bank_q, bank_d;
  logic [PER_W-1:0]            per_q, per_d;
  logic [WORDS-1:0][WORD_W-1:0] win_q, win_d;
  logic                        addr_ok;
  logic                        f_req, f_valid;
  logic [GIDX_W-1:0]           f_word;
  logic [PER_W-1:0]            f_per;
  logic [WORD_W-1:0]           f_data;

  assign addr_ok = (bank_addr[OFF_W-1:0] == '0) &&
                   ((bank_addr >> OFF_W) < WORD_W'(NUM_BANKS));

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    bank_d   = bank_q;
    per_d    = per_q;
    win_d    = win_q;
    done_set = 1'b0;
    f_req    = 1'b0;
    f_word   = {bank_q, idx_q};
    f_per    = per_q;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          win_d = '0;
          if (addr_ok) begin
            state_d = SQ_WAIT;
            idx_d   = '0;
            bank_d  = bank_addr[OFF_W +: BANK_IDX_W];
            per_d   = period;
            f_req   = 1'b1;
            f_word  = {bank_addr[OFF_W +: BANK_IDX_W], {WIDX_W{1'b0}}};
            f_per   = period;
          end else begin
            done_set = 1'b1;
          end
        end
      end
      SQ_WAIT: begin
        if (f_valid) begin
          win_d[idx_q] = f_data;
          if (idx_q == WIDX_W'(WORDS - 1)) begin
            state_d = SQ_FIN;
          end else begin
            idx_d  = idx_q + 1'b1;
            f_req  = 1'b1;
            f_word = {bank_q, WIDX_W'(idx_q + 1'b1)};
          end
        end
      end
      default: begin
        state_d  = SQ_IDLE;
        done_set = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      bank_q  <= '0;
      per_q   <= '0;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bank_q  <= bank_d;
      per_q   <= per_d;
      win_q   <= win_d;
    end
  end

  otp_fuse_model #(.WORD_W(WORD_W), .PER_W(PER_W), .GIDX_W(GIDX_W)) u_fuse (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .req        (f_req),
    .req_word   (f_word),
    .req_period (f_per),
    .resp_valid (f_valid),
    .resp_data  (f_data)
  );

  assign busy = (state_q != SQ_IDLE);
  assign win  = win_q;

  assert_resp_only_when_waiting_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    f_valid |-> (state_q == SQ_WAIT));
  assert_bad_addr_clears_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_IDLE && start && !addr_ok) |=> (state_q == SQ_IDLE && win_q == '0));
endmodule

// File: rtl/otp_bank_reader.sv
module otp_bank_reader #(
  parameter int NUM_BANKS = 8,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int PER_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  import otp_pkg::*;

  logic [1:0]                   rst_sync_q;
  logic                         rst_ni;
  logic [PER_W-1:0]             period_q, period_d;
  logic [WORD_W-1:0]            addr_q, addr_d;
  logic                         done_q, done_d;
  logic                         wr, ctrl_wr, stat_wr, addr_wr, start_acc;
  logic                         busy, done_set;
  logic [WORDS-1:0][WORD_W-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr        = bus_sel && bus_we;
  assign ctrl_wr   = wr && (bus_addr == OFF_CTRL);
  assign stat_wr   = wr && (bus_addr == OFF_STAT);
  assign addr_wr   = wr && (bus_addr == OFF_ADDR);
  assign start_acc = ctrl_wr && !busy && bus_wdata[START_BIT];

  always_comb begin
    period_d = period_q;
    addr_d   = addr_q;
    done_d   = done_q;
    if (ctrl_wr && !busy) period_d = bus_wdata[PER_LSB +: PER_W];
    if (addr_wr)          addr_d   = bus_wdata;
    if (stat_wr)          done_d   = done_q && bus_wdata[DONE_BIT];
    if (done_set)         done_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      addr_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      addr_q   <= addr_d;
      done_q   <= done_d;
    end
  end

  otp_read_seq #(.NUM_BANKS(NUM_BANKS), .WORDS(WORDS), .WORD_W(WORD_W), .PER_W(PER_W)) u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .start     (start_acc),
    .bank_addr (addr_q),
    .period    (period_d),
    .busy      (busy),
    .done_set  (done_set),
    .win       (win)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CTRL) begin
      bus_rdata[PER_LSB +: PER_W] = period_q;
      bus_rdata[START_BIT]        = busy;
    end else if (bus_addr == OFF_STAT) begin
      bus_rdata[DONE_BIT] = done_q;
    end else if (bus_addr == OFF_ADDR) begin
      bus_rdata = addr_q;
    end
    for (int i = 0; i < WORDS; i++) begin
      if (bus_addr == OFF_WIN + 8'(4 * i)) bus_rdata = win[i];
    end
  end

  assert_done_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_q) |-> !busy);
  assert_period_frozen_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(period_q));
  assert_done_cleared_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_wr && !bus_wdata[DONE_BIT] && !done_set) |=> !done_q);
endmodule

// File: tb/sim_otp_bank_reader.sv
module sim_otp_bank_reader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  int          n_chk = 0, n_fail = 0;
  int          cyc = 0;
  bit          finished = 1'b0;

  localparam logic [7:0] A_WIN = 8'h20, A_CTRL = 8'h48, A_STAT = 8'h4C, A_ADDR = 8'h50;
  localparam int NV = 6;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0, 32'h380, 32'h180, 32'h280, 32'h82, 32'h400};
  localparam logic [7:0]  V_PER  [NV] = '{8'd30, 8'd0, 8'd1, 8'd4, 8'd2, 8'd30};
  localparam bit          V_OK   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  otp_bank_reader u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [31:0] fuse_val(int g);
    return 32'h9E3779B9 * (32'(g) + 32'd1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; sel = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_done(int t0, output int k);
    k = -1;
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      #2 addr = A_STAT; we = 1'b0;
      #1;
      if (rdata[4]) begin
        k = cyc - t0;
        break;
      end
    end
  endtask

  initial begin
    logic [31:0] v;
    int t0, k;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = 8'h0; wdata = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    bus_read(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    bus_read(A_STAT, v); check("R1 status", v, 32'h0);
    bus_read(A_ADDR, v); check("R1 addr", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      bus_read(A_WIN + 8'(4 * i), v); check("R1 window", v, 32'h0);
    end

    // Vector table: R2 data, R3 timing, R6 bad address
    for (int j = 0; j < NV; j++) begin
      bus_write(A_STAT, 32'h0);
      bus_write(A_ADDR, V_ADDR[j]);
      bus_write(A_CTRL, {16'h0, V_PER[j], 8'h04});
      t0 = cyc;
      wait_done(t0, k);
      if (V_OK[j]) begin
        check("R3 done latency", 32'(k), 32'(4 * (int'(V_PER[j]) + 1) + 1));
        bus_read(A_CTRL, v); check("R3 start cleared", v, {16'h0, V_PER[j], 8'h00});
        for (int i = 0; i < 4; i++) begin
          bus_read(A_WIN + 8'(4 * i), v);
          check("R2 window word", v, fuse_val(int'(V_ADDR[j] >> 7) * 4 + i));
        end
      end else begin
        check("R6 immediate done", 32'(k), 32'd1);
        for (int i = 0; i < 4; i++) begin
          bus_read(A_WIN + 8'(4 * i), v); check("R6 window zero", v, 32'h0);
        end
      end
    end

    // R4: sticky done
    bus_write(A_STAT, 32'h10);
    bus_read(A_STAT, v); check("R4 write one keeps", v, 32'h10);
    repeat (5) @(posedge clk);
    bus_read(A_STAT, v); check("R4 stays set", v, 32'h10);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, v); check("R4 write zero clears", v, 32'h0);

    // R5: control and address writes during a read
    bus_write(A_ADDR, 32'h100);
    bus_write(A_CTRL, {16'h0, 8'd10, 8'h04});
    t0 = cyc;
    bus_write(A_CTRL, {16'h0, 8'd1, 8'h04});
    bus_write(A_ADDR, 32'h0);
    bus_read(A_CTRL, v); check("R5 period kept, R3 start busy", v, {16'h0, 8'd10, 8'h04});
    wait_done(t0, k);
    check("R5 timing unchanged", 32'(k), 32'd45);
    for (int i = 0; i < 4; i++) begin
      bus_read(A_WIN + 8'(4 * i), v); check("R5 bank kept", v, fuse_val(8 + i));
    end

    // R7: reserved control bits
    bus_write(A_STAT, 32'h0);
    bus_write(A_CTRL, 32'h0000_3B3B);
    bus_read(A_CTRL, v); check("R7 reserved bits zero", v, 32'h0000_3B00);
    bus_read(A_STAT, v); check("R7 no start", v, 32'h0);

    // R8: address readback and unmapped offsets
    bus_write(A_ADDR, 32'hDEAD_0380);
    bus_read(A_ADDR, v); check("R8 addr readback", v, 32'hDEAD_0380);
    bus_read(8'h10, v); check("R8 unmapped", v, 32'h0);
    bus_read(8'h30, v); check("R8 past window", v, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule